// File: doc/BRIEF.md
# Array Bound Check Sequencer

This block checks a signed array index against a pair of limits held in memory. A pulse on `start` captures the index, the address of the limit pair and an operand-size select. The sequencer then reads the lower limit from the base address. After that read completes it reads the upper limit from the next operand-sized slot. It compares the index against both limits and finishes with a one-cycle `done`. The same cycle also carries an exception request with a fixed vector when the index falls outside the limits.

The memory side is a simple read port. `rd_req` and `rd_addr` stay asserted until `rd_ready` is seen high, and `rd_data` is taken in that same cycle. In narrow mode the index and both limits are 16-bit two's-complement values. In wide mode they are 32-bit. The block holds no condition flags, and decoding and exception dispatch are handled elsewhere.

Top module: `bchk_unit`

## Requirements
- R1: While reset is asserted and right after it, `rd_req`, `done`, `exc` are low and `exc_vec` is zero.
- R2: A `start` seen in the idle state issues a read at `bc_base` at once. `rd_req` and `rd_addr` are held unchanged until the cycle in which `rd_ready` is high.
- R3: After the lower read is accepted, the next cycle issues the upper read at `bc_base + 2` when `bc_wide` was 0, or at `bc_base + 4` when `bc_wide` was 1. Address and request are held until `rd_ready`.
- R4: With `bc_wide` = 0, only bits [15:0] of the index and of each `rd_data` word are used, as signed 16-bit values. Upper bits have no effect on the result.
- R5: With `bc_wide` = 1, the index and both limits are full 32-bit signed values.
- R6: An index equal to the lower limit or equal to the upper limit is in range: `exc` stays low.
- R7: An index below the lower limit or above the upper limit raises `exc` with `exc_vec` = 5 in the `done` cycle. `exc` is never high outside a `done` cycle, and `exc_vec` is 0 whenever `exc` is low.
- R8: `done` is high for exactly one cycle per accepted start. That cycle is the second cycle after the cycle in which the upper read was accepted, and no read is requested during it.
- R9: `start` and the operand inputs are ignored while an operation is in progress. No extra operation is launched, and the captured index, base and size are not changed.
- R10: When the lower limit exceeds the upper limit, every index raises the exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a check (taken only when idle) |
| bc_index | input | IDX_W | Index value to check |
| bc_base | input | ADDR_W | Address of the lower limit |
| bc_wide | input | 1 | 0: 16-bit operands, 1: 32-bit operands |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Memory read address |
| rd_data | input | IDX_W | Memory read data, valid with rd_ready |
| rd_ready | input | 1 | Read accepted and data valid this cycle |
| done | output | 1 | One-cycle completion pulse |
| exc | output | 1 | Out-of-range exception request, valid with done |
| exc_vec | output | VEC_W | Exception vector (5 when exc, else 0) |

## Verification
The assertions take `rd_ready` to matter only while `rd_req` is high. They also take `rd_data` to be the word at `rd_addr` in the cycle `rd_ready` is sampled. The bench serves reads from a small model that answers only the two limit addresses of the captured base. It drives `rd_ready` either always high or from a random pattern, and it raises it freely while no request is pending. The bench also pulses `start` with altered operands during busy cycles. This shows the design does not depend on the driver keeping `start` quiet.

// File: rtl/bchk_pkg.sv
package bchk_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RD_LO = 3'd1,
      ST_RD_HI = 3'd2,
      ST_CMP   = 3'd3,
      ST_FIN   = 3'd4
   } bchk_state_e;

   localparam int unsigned LIM_LO   = 0;
   localparam int unsigned LIM_HI   = 1;
   localparam int unsigned NUM_LIMS = 2;

endpackage

// File: rtl/bchk_seq.sv
module bchk_seq
   import bchk_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                rd_ready,
   output logic                cap_op,
   output logic [NUM_LIMS-1:0] cap_lim,
   output logic                sel_hi,
   output logic                rd_req,
   output logic                cmp_en,
   output logic                fin
);

   bchk_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (start)    state_d = ST_RD_LO;
         ST_RD_LO: if (rd_ready) state_d = ST_RD_HI;
         ST_RD_HI: if (rd_ready) state_d = ST_CMP;
         ST_CMP:                 state_d = ST_FIN;
         ST_FIN:                 state_d = ST_IDLE;
         default:                state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign cap_op          = (state_q == ST_IDLE) && start;
   assign cap_lim[LIM_LO] = (state_q == ST_RD_LO) && rd_ready;
   assign cap_lim[LIM_HI] = (state_q == ST_RD_HI) && rd_ready;
   assign sel_hi          = (state_q == ST_RD_HI);
   assign rd_req          = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
   assign cmp_en          = (state_q == ST_CMP);
   assign fin             = (state_q == ST_FIN);

endmodule

// File: rtl/bchk_operands.sv
module bchk_operands
   import bchk_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned IDX_W       = 32,
   parameter int unsigned NARROW_W    = 16,
   parameter int unsigned STEP_NARROW = 2,
   parameter int unsigned STEP_WIDE   = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cap_op,
   input  logic [NUM_LIMS-1:0]      cap_lim,
   input  logic                     sel_hi,
   input  logic [IDX_W-1:0]         idx_in,
   input  logic [ADDR_W-1:0]        base_in,
   input  logic                     wide_in,
   input  logic [IDX_W-1:0]         rd_data,
   output logic [ADDR_W-1:0]        rd_addr,
   output logic                     wide_q,
   output logic signed [IDX_W-1:0]  idx_q,
   output logic signed [IDX_W-1:0]  lo_q,
   output logic signed [IDX_W-1:0]  hi_q
);

   localparam logic [ADDR_W-1:0] OFF_N = ADDR_W'(STEP_NARROW);
   localparam logic [ADDR_W-1:0] OFF_W = ADDR_W'(STEP_WIDE);

   logic [ADDR_W-1:0]  base_q;
   logic [IDX_W-1:0]   idx_fit;
   logic [IDX_W-1:0]   data_fit;
   logic [IDX_W-1:0]   lim_q [NUM_LIMS];

   // Width adaptation: sign-extend the narrow lane when a narrow mode exists.
   generate
      if (IDX_W > NARROW_W) begin : g_two_sizes
         assign idx_fit  = wide_in ? idx_in
                         : {{(IDX_W-NARROW_W){idx_in[NARROW_W-1]}}, idx_in[NARROW_W-1:0]};
         assign data_fit = wide_q ? rd_data
                         : {{(IDX_W-NARROW_W){rd_data[NARROW_W-1]}}, rd_data[NARROW_W-1:0]};
      end else begin : g_one_size
         assign idx_fit  = idx_in;
         assign data_fit = rd_data;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         wide_q <= 1'b0;
         idx_q  <= '0;
      end else if (cap_op) begin
         base_q <= base_in;
         wide_q <= wide_in;
         idx_q  <= idx_fit;
      end
   end

   // One capture register per limit slot.
   generate
      for (genvar g = 0; g < NUM_LIMS; g++) begin : g_lim
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          lim_q[g] <= '0;
            else if (cap_lim[g]) lim_q[g] <= data_fit;
         end
      end
   endgenerate

   assign lo_q    = lim_q[LIM_LO];
   assign hi_q    = lim_q[LIM_HI];
   assign rd_addr = base_q + (sel_hi ? (wide_q ? OFF_W : OFF_N) : '0);

endmodule

// File: rtl/bchk_range.sv
module bchk_range #(
   parameter int unsigned W = 32
) (
   input  logic signed [W-1:0] idx,
   input  logic signed [W-1:0] lo,
   input  logic signed [W-1:0] hi,
   output logic                outside
);

   logic below, above;

   assign below   = idx < lo;
   assign above   = idx > hi;
   assign outside = below | above;

endmodule

// File: rtl/bchk_unit.sv
module bchk_unit
   import bchk_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned IDX_W       = 32,
   parameter int unsigned NARROW_W    = 16,
   parameter int unsigned STEP_NARROW = 2,
   parameter int unsigned STEP_WIDE   = 4,
   parameter int unsigned VEC_W       = 8,
   parameter int unsigned VECTOR      = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [IDX_W-1:0]  bc_index,
   input  logic [ADDR_W-1:0] bc_base,
   input  logic              bc_wide,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [IDX_W-1:0]  rd_data,
   input  logic              rd_ready,
   output logic              done,
   output logic              exc,
   output logic [VEC_W-1:0]  exc_vec
);

   localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(VECTOR);

   generate
      if (IDX_W < NARROW_W) begin : g_bad_idx
         $error("IDX_W must be at least NARROW_W");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W too small");
      end
      if (VECTOR >= (1 << VEC_W)) begin : g_bad_vec
         $error("VECTOR does not fit VEC_W");
      end
      if (STEP_NARROW == 0 || STEP_WIDE == 0) begin : g_bad_step
         $error("limit slot steps must be non-zero");
      end
   endgenerate

   logic                    cap_op, sel_hi, cmp_en, fin, outside, exc_q, wide_q;
   logic [NUM_LIMS-1:0]     cap_lim;
   logic signed [IDX_W-1:0] idx_q, lo_q, hi_q;

   bchk_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .rd_ready (rd_ready),
      .cap_op   (cap_op),
      .cap_lim  (cap_lim),
      .sel_hi   (sel_hi),
      .rd_req   (rd_req),
      .cmp_en   (cmp_en),
      .fin      (fin)
   );

   bchk_operands #(
      .ADDR_W      (ADDR_W),
      .IDX_W       (IDX_W),
      .NARROW_W    (NARROW_W),
      .STEP_NARROW (STEP_NARROW),
      .STEP_WIDE   (STEP_WIDE)
   ) u_ops (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_op  (cap_op),
      .cap_lim (cap_lim),
      .sel_hi  (sel_hi),
      .idx_in  (bc_index),
      .base_in (bc_base),
      .wide_in (bc_wide),
      .rd_data (rd_data),
      .rd_addr (rd_addr),
      .wide_q  (wide_q),
      .idx_q   (idx_q),
      .lo_q    (lo_q),
      .hi_q    (hi_q)
   );

   bchk_range #(.W(IDX_W)) u_range (
      .idx     (idx_q),
      .lo      (lo_q),
      .hi      (hi_q),
      .outside (outside)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      exc_q <= 1'b0;
      else if (cmp_en) exc_q <= outside;
   end

   assign done    = fin;
   assign exc     = fin & exc_q;
   assign exc_vec = exc ? VEC_VAL : '0;

endmodule

// File: rtl/bchk_unit_chk.sv
module bchk_unit_chk #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned STEP_NARROW = 2,
   parameter int unsigned STEP_WIDE   = 4,
   parameter int unsigned VEC_W       = 8,
   parameter int unsigned VECTOR      = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_req,
   input logic              rd_ready,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              done,
   input logic              exc,
   input logic [VEC_W-1:0]  exc_vec,
   input logic              wide_q
);

   localparam logic [ADDR_W-1:0] OFF_N = ADDR_W'(STEP_NARROW);
   localparam logic [ADDR_W-1:0] OFF_W = ADDR_W'(STEP_WIDE);

   logic seen_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 seen_lo <= 1'b0;
      else if (rd_req && rd_ready) seen_lo <= !seen_lo;
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr))); // R2

   AST_HI_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_ready && !seen_lo) |=>
         (rd_req && rd_addr == $past(rd_addr) + (wide_q ? OFF_W : OFF_N))); // R3

   AST_DONE_AFTER_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_ready && seen_lo) |=> ##1 done); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !rd_req); // R8

   AST_EXC_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      exc |-> (done && exc_vec == VEC_W'(VECTOR))); // R7

   AST_VEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (exc_vec == '0)); // R7

endmodule

bind bchk_unit bchk_unit_chk #(
   .ADDR_W      (ADDR_W),
   .STEP_NARROW (STEP_NARROW),
   .STEP_WIDE   (STEP_WIDE),
   .VEC_W       (VEC_W),
   .VECTOR      (VECTOR)
) u_bchk_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_req   (rd_req),
   .rd_ready (rd_ready),
   .rd_addr  (rd_addr),
   .done     (done),
   .exc      (exc),
   .exc_vec  (exc_vec),
   .wide_q   (wide_q)
);

// File: tb/test_bchk_unit.sv
module test_bchk_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] bc_index = '0;
   logic [31:0] bc_base = '0;
   logic        bc_wide = 1'b0;
   logic        rd_req;
   logic [31:0] rd_addr;
   logic [31:0] rd_data;
   logic        rd_ready = 1'b0;
   logic        done, exc;
   logic [7:0]  exc_vec;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;
   bit rnd_ready = 1'b0;

   // reference model state
   int          mph = 0;
   logic [31:0] m_idx, m_base, m_lo, m_hi;
   logic        m_wide;
   logic [31:0] lo_word = '0, hi_word = '0;

   always #4 clk = ~clk;

   bchk_unit i_bchk_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .bc_index(bc_index),
      .bc_base(bc_base), .bc_wide(bc_wide), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_data(rd_data), .rd_ready(rd_ready), .done(done), .exc(exc),
      .exc_vec(exc_vec)
   );

   assign rd_data = (rd_addr == m_base) ? lo_word :
                    (rd_addr == m_base + (m_wide ? 32'd4 : 32'd2)) ? hi_word :
                    32'hBAD0_BAD0;

   function automatic bit out_of_range(logic [31:0] i, logic [31:0] l, logic [31:0] h, bit w);
      int si, sl, sh;
      si = w ? int'(i) : int'(shortint'(i[15:0]));
      sl = w ? int'(l) : int'(shortint'(l[15:0]));
      sh = w ? int'(h) : int'(shortint'(h[15:0]));
      return (si < sl) || (si > sh);
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) mph <= 0;
      else case (mph)
         0: if (start) begin
               mph <= 1; m_idx <= bc_index; m_base <= bc_base; m_wide <= bc_wide;
            end
         1: if (rd_ready) begin m_lo <= rd_data; mph <= 2; end
         2: if (rd_ready) begin m_hi <= rd_data; mph <= 3; end
         3: mph <= 4;
         default: mph <= 0;
      endcase
   end

   // per-cycle comparison against the model, plus ready pattern
   always @(negedge clk) begin
      if (!rst_n) begin
         chk(!rd_req && !done && !exc && exc_vec == 0, "R1", {rd_req, done, exc}, 0);
      end else if (!finished) begin
         bit ev, ex;
         ev = (mph == 4) && out_of_range(m_idx, m_lo, m_hi, m_wide);
         chk(rd_req == (mph == 1 || mph == 2), "R2", rd_req, (mph == 1 || mph == 2));
         if (mph == 1) chk(rd_addr == m_base, "R2", rd_addr, m_base);
         if (mph == 2) chk(rd_addr == m_base + (m_wide ? 4 : 2), "R3", rd_addr,
                           m_base + (m_wide ? 4 : 2));
         chk(done == (mph == 4), "R8", done, (mph == 4));
         chk(exc == ev, "R7", exc, ev);
         ex = ev;
         chk(exc_vec == (ex ? 8'd5 : 8'd0), "R7", exc_vec, ex ? 5 : 0);
      end
      rd_ready <= rnd_ready ? ($urandom_range(0, 3) == 0) : 1'b1;
   end

   task automatic do_op(input logic [31:0] idx, input logic [31:0] base, input bit wide,
                        input logic [31:0] lo, input logic [31:0] hi, input bit poke,
                        input bit hand, input bit exp_exc, input string tag);
      @(negedge clk);
      lo_word = lo; hi_word = hi;
      bc_index = idx; bc_base = base; bc_wide = wide; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (mph != 0) begin
         if (mph == 4 && hand) chk(exc == exp_exc, tag, exc, exp_exc);
         if (poke && (mph == 1 || mph == 2 || mph == 3)) begin
            start = 1'b1; bc_index = ~idx; bc_base = base + 32'h100; bc_wide = !wide;
         end else start = 1'b0;
         @(negedge clk);
      end
      start = 1'b0;
   endtask

   task automatic wrap_up;
      if (!finished) begin
         finished = 1'b1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      wrap_up();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!rd_req && !done && !exc, "R1", {rd_req, done, exc}, 0);
      // narrow: junk upper bits ignored, -2..10
      do_op(32'hFFFF_0005, 32'h40, 0, 32'h1234_FFFE, 32'h9999_000A, 0, 1, 0, "R4");
      do_op(32'h0000_FFF0, 32'h40, 0, 32'h1234_FFFE, 32'h9999_000A, 0, 1, 1, "R7");
      do_op(32'h7777_FFFE, 32'h80, 0, 32'h1234_FFFE, 32'h9999_000A, 0, 1, 0, "R6");
      do_op(32'h0000_000A, 32'h80, 0, 32'h1234_FFFE, 32'h9999_000A, 0, 1, 0, "R6");
      do_op(32'h0000_000B, 32'h80, 0, 32'h1234_FFFE, 32'h9999_000A, 0, 1, 1, "R7");
      // wide
      do_op(32'h0001_0000, 32'h100, 1, 32'h0000_0100, 32'h0002_0000, 0, 1, 0, "R5");
      do_op(32'h8000_0000, 32'h100, 1, 32'hFFFF_FFFF, 32'h0000_0005, 0, 1, 1, "R5");
      do_op(32'h7FFF_FFFF, 32'h200, 1, 32'h0000_0000, 32'h7FFF_FFFF, 0, 1, 0, "R6");
      do_op(32'h0000_0007, 32'h200, 1, 32'h0000_000A, 32'h0000_0005, 0, 1, 1, "R10");
      do_op(32'h0000_0007, 32'h204, 0, 32'h0000_000A, 32'h0000_0005, 0, 1, 1, "R10");
      // busy-time starts ignored
      rnd_ready = 1'b1;
      do_op(32'hFFFF_0005, 32'h40, 0, 32'h1234_FFFE, 32'h9999_000A, 1, 1, 0, "R9");
      do_op(32'h0000_0200, 32'h300, 1, 32'h0000_0000, 32'h0000_0300, 1, 1, 0, "R9");
      for (int k = 0; k < 60; k++) begin
         logic [31:0] a, b;
         a = $urandom_range(0, 40) - 20;
         b = $urandom_range(0, 40) - 20;
         do_op($urandom_range(0, 50) - 25, 32'($urandom_range(0, 255)) << 3,
               bit'(k % 2), a, b, bit'(k % 3 == 0), 0, 0, "R7");
      end
      repeat (3) @(negedge clk);
      wrap_up();
   end

endmodule